// File: doc/BRIEF.md
# USB Host Interrupt Status Controller

This block gathers event flags from a USB host controller and drives one level-sensitive interrupt line. Event sources deliver one-cycle pulses: frame timer, root hub, done-queue writeback and error logic. Each pulse latches a sticky bit in a status register. Software clears these bits by writing ones to them.

An enable register selects which pending events can raise the interrupt. Its top bit is a master enable that gates the whole line. Software uses two separate write addresses, one to set enable bits and one to clear them, so it never needs a read-modify-write to change them.

A minimal register port carries a write strobe, a two-bit word address, write data and combinational read data. The interrupt output is registered.

Top module: `usb_irq_ctrl`

## Requirements
- R1: After reset the status register reads 0, the enable register reads 0x8000_0000 (master enable only), and irq_o is low.
- R2: A pulse on evt_i[k] sets a status bit on the next clock edge. Indices k=0..6 map to status bits 0..6: scheduling overrun, writeback, start of frame, resume, unrecoverable error, frame overflow, root hub change. Index k=7 maps to status bit 30, ownership change.
- R3: A write to address 0 clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R4: When an event and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R5: A write to address 1 sets the enable bits selected by ones in the write data. A write to address 2 clears them. Reads of address 1 and address 2 both return the enable register.
- R6: irq_o equals enable bit 31 AND (status AND enable bits 30..0 is nonzero). The value is taken from the state before the previous clock edge, so irq_o follows a cause by one cycle.
- R7: Bit positions outside the defined set read as 0 and ignore writes. For status the defined set is 0..6 and 30. Enable adds bit 31. Address 3 reads 0 and writes to it change nothing.
- R8: With master enable cleared, irq_o stays low while events keep setting status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | One-cycle event pulses; index order as in R2 |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word address: 0 status, 1 enable set, 2 enable clear, 3 unused |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Registered interrupt level |

## Verification
The hardest case to reach is a status bit that is pulsed and cleared in the same cycle. The bench drives an event pulse and a clearing write for that bit in one step, then reads the status back. A second hard case is pending, enabled events with the master enable off. The bench clears bit 31 through the clear address, keeps injecting events, and confirms from the status reads that the events were recorded while the line stayed low. A long randomized phase then mixes events, writes to all four addresses and reads against a behavioural model on every clock.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int NUM_EVT = 8;
  localparam int MIE_BIT = 31;
  localparam int EVT_POS [NUM_EVT] = '{0, 1, 2, 3, 4, 5, 6, 30};

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_EN_SET = 2'd1,
    REG_EN_CLR = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  function automatic logic [DATA_W-1:0] evt_to_bits(input logic [NUM_EVT-1:0] e);
    logic [DATA_W-1:0] b;
    b = '0;
    for (int k = 0; k < NUM_EVT; k++) b[EVT_POS[k]] = e[k];
    return b;
  endfunction

  localparam logic [DATA_W-1:0] STS_MASK = evt_to_bits({NUM_EVT{1'b1}});
  localparam logic [DATA_W-1:0] EN_MASK  = STS_MASK | (DATA_W'(1) << MIE_BIT);
endpackage

// File: rtl/usb_irq_evt_map.sv
module usb_irq_evt_map
  import usb_irq_pkg::*;
(
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [DATA_W-1:0]  bits_o
);
  logic [DATA_W-1:0] spread;
  always_comb begin
    spread = '0;
    for (int k = 0; k < NUM_EVT; k++) spread[EVT_POS[k]] = evt_i[k];
  end
  assign bits_o = spread & STS_MASK;
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
  import usb_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q;
  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= ((q & ~clr_i) | set_i) & STS_MASK;
  end
  assign q_o = q;
endmodule

// File: rtl/usb_irq_enable.sv
module usb_irq_enable
  import usb_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] q_o
);
  localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(1) << MIE_BIT;
  logic [DATA_W-1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST_VAL;
    else         q <= ((q & ~clr_i) | set_i) & EN_MASK;
  end
  assign q_o = q;
endmodule

// File: rtl/usb_irq_line.sv
module usb_irq_line
  import usb_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] enable_i,
  output logic              irq_o
);
  logic [DATA_W-1:0] gated;
  logic              irq_q;
  assign gated = status_i & enable_i & STS_MASK;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= enable_i[MIE_BIT] & (|gated);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] evt_bits, sts_clr, en_set, en_clr;
  logic [DATA_W-1:0] status_q, enable_q;

  assign sel     = reg_sel_e'(addr_i);
  assign sts_clr = (we_i && sel == REG_STATUS) ? wdata_i : '0;
  assign en_set  = (we_i && sel == REG_EN_SET) ? wdata_i : '0;
  assign en_clr  = (we_i && sel == REG_EN_CLR) ? wdata_i : '0;

  usb_irq_evt_map u_map (.evt_i(evt_i), .bits_o(evt_bits));

  usb_irq_status u_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(evt_bits), .clr_i(sts_clr), .q_o(status_q)
  );

  usb_irq_enable u_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(en_set), .clr_i(en_clr), .q_o(enable_q)
  );

  usb_irq_line u_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .status_i(status_q), .enable_i(enable_q), .irq_o(irq_o)
  );

  always_comb begin
    unique case (sel)
      REG_STATUS:             rdata_o = status_q;
      REG_EN_SET, REG_EN_CLR: rdata_o = enable_q;
      default:                rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/usb_irq_ctrl_chk.sv
module usb_irq_ctrl_chk
  import usb_irq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [DATA_W-1:0]  status_q,
  input logic [DATA_W-1:0]  enable_q,
  input logic               irq_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_irq_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> irq_o == ($past(enable_q[MIE_BIT]) &&
                          ((($past(status_q) & $past(enable_q)) & STS_MASK) != '0)));

  assert_mie_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(enable_q[MIE_BIT])) |-> !irq_o);

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
    assert_evt_sets_R2_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> status_q[EVT_POS[k]]);
    assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == 2'd0 && wdata_i[EVT_POS[k]] && !evt_i[k]) |=> !status_q[EVT_POS[k]]);
  end

  assert_en_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd1) |=> ((enable_q & $past(wdata_i) & EN_MASK) == ($past(wdata_i) & EN_MASK)));

  assert_en_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd2) |=> ((enable_q & $past(wdata_i)) == '0));

  assert_undef_bits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdata_o & ~EN_MASK) == '0) && (addr_i != 2'd3 || rdata_o == '0));
endmodule

bind usb_irq_ctrl usb_irq_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .status_q(status_q), .enable_q(enable_q), .irq_o(irq_o)
);

// File: tb/tb_usb_irq_ctrl.sv
`timescale 1ns/1ps
module tb_usb_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  evt_i = '0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  bit [31:0] m_sts, m_en;
  bit        m_irq;
  bit        finished = 0;

  always #2 clk_i = ~clk_i;

  usb_irq_ctrl dut (.*);

  function automatic bit [31:0] ev_bits(input bit [7:0] e);
    int pos [8] = '{0, 1, 2, 3, 4, 5, 6, 30};
    bit [31:0] b = 0;
    foreach (e[k]) if (e[k]) b[pos[k]] = 1'b1;
    return b;
  endfunction

  task automatic check(input string req, input bit [31:0] act, input bit [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, check reads, update model at edge, check irq
  task automatic step(input bit [7:0] ev, input bit we, input bit [1:0] a,
                      input bit [31:0] wd, input string req);
    bit [31:0] exp_rd, n_sts, n_en;
    bit n_irq;
    @(negedge clk_i);
    evt_i = ev; we_i = we; addr_i = a; wdata_i = wd;
    #1;
    exp_rd = (a == 0) ? m_sts : (a == 3) ? 32'h0 : m_en;
    check({req, " read"}, rdata_o, exp_rd);
    n_irq = m_en[31] && ((m_sts & m_en & 32'h7fff_ffff) != 0);
    n_sts = m_sts;
    n_en  = m_en;
    if (we && a == 0) n_sts &= ~wd;
    n_sts = (n_sts | ev_bits(ev)) & 32'h4000_007f;
    if (we && a == 1) n_en = (n_en | wd) & 32'hc000_007f;
    if (we && a == 2) n_en = n_en & ~wd;
    @(posedge clk_i);
    m_sts = n_sts; m_en = n_en; m_irq = n_irq;
    @(negedge clk_i);
    check({req, " irq"}, {31'b0, irq_o}, {31'b0, m_irq});
    evt_i = '0; we_i = 1'b0;
  endtask

  initial begin
    m_sts = 0; m_en = 32'h8000_0000; m_irq = 0;
    repeat (3) @(negedge clk_i);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    rst_ni = 1'b1;
    step(0, 0, 0, 0, "R1 status");
    step(0, 0, 1, 0, "R1 enable");
    // each event alone, then clear it
    for (int k = 0; k < 8; k++) begin
      step(8'(1 << k), 0, 0, 0, "R2");
      step(0, 0, 0, 0, "R2");
      step(0, 1, 0, 32'hffff_ffff, "R3");
      step(0, 0, 0, 0, "R3");
    end
    step(0, 1, 1, 32'h0000_0004, "R5");
    step(0, 0, 2, 0, "R5");
    step(8'h04, 0, 0, 0, "R6");
    step(0, 0, 0, 0, "R6");
    step(0, 1, 0, 32'h0, "R3");
    step(8'h04, 1, 0, 32'h0000_0004, "R4");
    step(0, 0, 0, 0, "R4");
    step(0, 1, 2, 32'h8000_0000, "R8");
    step(8'h81, 0, 0, 0, "R8");
    step(0, 0, 0, 0, "R8");
    step(0, 1, 1, 32'hffff_ffff, "R7");
    step(0, 0, 1, 0, "R7");
    step(0, 1, 3, 32'hffff_ffff, "R7");
    step(0, 0, 3, 0, "R7");
    step(0, 0, 0, 0, "R6");
    for (int i = 0; i < 600; i++)
      step(8'($urandom_range(0, 255) & $urandom_range(0, 255)), 1'($urandom_range(0, 1)),
           2'($urandom_range(0, 3)), $urandom, "R6");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule